// File: doc/BRIEF.md
# Eight-Operation Combinational ALU

This block is a small arithmetic logic unit with no clock and no stored state. It takes two 8-bit unsigned operands, `a_i` and `b_i`, and a 3-bit operation code. From these it forms a 16-bit result. Each operation is written with the `b_i` operand on the left, so subtract gives `b_i - a_i` and divide gives `b_i / a_i`.

Two comparison flags are always driven from the operands, whatever the operation code is. One reports that the operands are equal. The other reports that `b_i` is strictly larger than `a_i`.

The operand width is a parameter, and the result is always twice that width. When the divisor is zero, divide and remainder give a defined value, so the output never carries an unknown.

Top module: `alu8`

## Requirements
- R1: With `op_i` = 3'b000, `res_o` equals `b_i + a_i`, zero-extended to 16 bits. A carry appears in bit 8.
- R2: With `op_i` = 3'b001, `res_o` equals `b_i - a_i` modulo 2^16. When `b_i < a_i`, the result is the 16-bit two's-complement wrap.
- R3: With `op_i` = 3'b010, `res_o` equals the full 16-bit unsigned product `b_i * a_i`.
- R4: With `op_i` = 3'b011, `res_o` equals the unsigned integer quotient `b_i / a_i`. When `a_i` is zero, the result is 16'hFFFF.
- R5: With `op_i` = 3'b100, `res_o` equals the unsigned remainder `b_i % a_i`. When `a_i` is zero, the result is `b_i` zero-extended.
- R6: With `op_i` = 3'b101, 3'b110 and 3'b111, `res_o` equals the bitwise AND, OR and XOR of `b_i` and `a_i` respectively. The upper 8 bits are zero.
- R7: `eq_o` is 1 exactly when `b_i == a_i`, for every value of `op_i`.
- R8: `gt_o` is 1 exactly when `b_i > a_i` as unsigned values, for every value of `op_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Right-hand operand (addend, subtrahend, divisor) |
| b_i | input | 8 | Left-hand operand (minuend, dividend) |
| op_i | input | 3 | Operation code |
| res_o | output | 16 | Operation result |
| eq_o | output | 1 | Operands are equal |
| gt_o | output | 1 | `b_i` greater than `a_i` |

## Verification
The assertions check these properties whenever the inputs change:
- The two flags are never high together.
- The bitwise results and the sum stay within their zero-extended width.
- A nonzero-divisor quotient times the divisor never exceeds the dividend.
- A remainder stays below its divisor.
- A zero divisor yields all ones for divide and the dividend for remainder.

The assertions cannot show that each exact value is right, nor that the flags stay unaffected by the operation code. Only the bench scenarios show this. They sweep all eight codes over fixed operand pairs, which include a zero divisor, equal operands, and both orderings of unequal operands. The bench compares each result and flag against a reference model.

// File: rtl/alu8.sv
module alu8 #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [2:0]     op_i,
  output logic [2*W-1:0] res_o,
  output logic           eq_o,
  output logic           gt_o
);
  localparam int RW = 2 * W;

  logic [RW-1:0] xa, xb;
  logic          zdiv;

  assign xa   = {{W{1'b0}}, a_i};
  assign xb   = {{W{1'b0}}, b_i};
  assign zdiv = (a_i == '0);

  always_comb begin
    case (op_i)
      3'b000:  res_o = xb + xa;
      3'b001:  res_o = xb - xa;
      3'b010:  res_o = xb * xa;
      3'b011:  res_o = zdiv ? {RW{1'b1}} : xb / xa;
      3'b100:  res_o = zdiv ? xb : xb % xa;
      3'b101:  res_o = xb & xa;
      3'b110:  res_o = xb | xa;
      default: res_o = xb ^ xa;
    endcase
  end

  assign eq_o = (b_i == a_i);
  assign gt_o = (b_i > a_i);

  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      // R7
      flags_excl_chk: assert (!(eq_o && gt_o));
      // R6
      bitwise_hi_zero_chk: assert (!(op_i >= 3'b101) || res_o[RW-1:W] == '0);
      // R1
      sum_width_chk: assert (!(op_i == 3'b000) || res_o[RW-1:W+1] == '0);
      // R4
      quot_bound_chk: assert (!(op_i == 3'b011 && !zdiv) ||
        ({{W{1'b0}}, res_o} * {{RW{1'b0}}, a_i}) <= {{RW{1'b0}}, xb});
      // R4
      div_zero_chk: assert (!(op_i == 3'b011 && zdiv) || (&res_o));
      // R5
      rem_bound_chk: assert (!(op_i == 3'b100 && !zdiv) || res_o < xa);
      // R5
      rem_zero_chk: assert (!(op_i == 3'b100 && zdiv) || res_o == xb);
    end
  end
endmodule

// File: tb/tb_alu8.sv
module tb_alu8;
  logic        clk = 1'b0;
  logic [7:0]  a, b;
  logic [2:0]  op;
  logic [15:0] res;
  logic        eq, gt;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  alu8 dut (.a_i(a), .b_i(b), .op_i(op), .res_o(res), .eq_o(eq), .gt_o(gt));

  function automatic int model(int o, int x, int y);
    case (o)
      0: return y + x;
      1: return (y - x) & 16'hFFFF;
      2: return y * x;
      3: return (x == 0) ? 16'hFFFF : y / x;
      4: return (x == 0) ? y : y % x;
      5: return y & x;
      6: return y | x;
      default: return y ^ x;
    endcase
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d op=%0d got=%0d expected=%0d", req, a, b, op, got, exp);
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int pa [10] = '{0, 100, 10, 42, 7, 0, 255, 1, 200, 3};
    int pb [10] = '{0, 10, 100, 42, 42, 200, 255, 0, 5, 250};
    string tag [8] = '{"R1", "R2", "R3", "R4", "R5", "R6", "R6", "R6"};
    a = '0; b = '0; op = '0;
    for (int p = 0; p < 10; p++) begin
      for (int o = 0; o < 8; o++) begin
        @(posedge clk);
        a = pa[p][7:0];
        b = pb[p][7:0];
        op = o[2:0];
        @(negedge clk);
        check(tag[o], int'(res), model(o, pa[p], pb[p]));
        check("R7", int'(eq), int'(pb[p] == pa[p]));
        check("R8", int'(gt), int'(pb[p] > pa[p]));
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule